// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block sequences the instruction address of a small 8-bit controller core and keeps the return addresses it needs. An 11-bit program counter advances by one for a normal instruction or by two when a conditional skip is taken. It can also be loaded with an absolute target for a jump or call, or have only its low byte overwritten or offset for a computed branch. An interrupt sends it to a fixed vector. Calls and interrupts save a return address in an 8-entry last-in first-out store, and a return restores it.

The decoder drives one-cycle control pulses together with a target address or a byte operand. Every result is registered. The PC, the stack pointer and two sticky error flags appear on the outputs for observation. When several pulses arrive in the same cycle, a fixed priority picks the one that acts.

Top module: `pcs_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the PC to 0x000, the stack pointer to 3'b111, and clears both error flags.
- R2: A step pulse adds 1 to the PC and a skip pulse adds 2. Both wrap modulo 2^11.
- R3: A jump loads `target_i` into all 11 PC bits. A call does the same and also pushes the address of the next instruction (PC+1) onto the stack.
- R4: An interrupt pulse pushes the current PC, unchanged, and loads 0x008. It wins over every other pulse in the same cycle.
- R5: The stack pointer starts at 3'b111 and drops by one on each push until it reaches 3'b000 at level 7. It stays at 3'b000 at level 8 and rises by one on each pop. Entries come back in reverse order of saving.
- R6: A low-write pulse replaces PC bits 7:0 with `low_val_i`. A low-add pulse adds `low_val_i` to PC bits 7:0. Bits 10:8 stay unchanged in both cases, and a carry out of the addition is discarded.
- R7: A push while 8 levels are held sets `overflow_o`, which stays set until reset. It stores nothing and leaves the stack pointer alone, but the PC still loads its new value.
- R8: A return loads the most recently saved entry into the PC and removes it. A return on an empty stack leaves the PC and the stack pointer (3'b111) unchanged and sets `underflow_o`, which stays set until reset.
- R9: Priority from highest to lowest is interrupt, call, return, jump, low write, low add, skip, step. When call and return coincide, the call takes place and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Advance PC by one |
| skip_i | input | 1 | Advance PC by two (skip taken) |
| jump_i | input | 1 | Load absolute target |
| call_i | input | 1 | Push PC+1 and load target |
| ret_i | input | 1 | Pop top entry into PC |
| irq_i | input | 1 | Push PC and go to interrupt vector |
| low_wr_i | input | 1 | Replace PC low byte |
| low_add_i | input | 1 | Add to PC low byte without carry out |
| target_i | input | 11 | Jump or call destination |
| low_val_i | input | 8 | Byte for low write or low add |
| pc_o | output | 11 | Program counter |
| sp_o | output | 3 | Stack pointer |
| overflow_o | output | 1 | Sticky push-when-full flag |
| underflow_o | output | 1 | Sticky pop-when-empty flag |

## Verification
Every pulse takes effect at the first rising edge that samples it. The new PC, stack pointer and flag values are therefore due one clock after the pulse. The bench drives each pulse pattern on a falling edge and compares all four outputs on the next falling edge, after exactly one rising edge. Expected values come from an arithmetic model of the priority rules and the stack. A sweep of all 256 pulse combinations, starting from empty, partly full and full stacks, exercises the priority order and both flags.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [3:0] {
      OP_HOLD, OP_STEP, OP_SKIP, OP_LADD, OP_LWR,
      OP_JUMP, OP_RET, OP_CALL, OP_IRQ
   } pc_op_e;
endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
   import pcs_pkg::*;
(
   input  logic    step_i,
   input  logic    skip_i,
   input  logic    jump_i,
   input  logic    call_i,
   input  logic    ret_i,
   input  logic    irq_i,
   input  logic    low_wr_i,
   input  logic    low_add_i,
   output pc_op_e  op_o
);
   // R9: fixed priority chain
   always_comb begin
      if (irq_i)          op_o = OP_IRQ;
      else if (call_i)    op_o = OP_CALL;
      else if (ret_i)     op_o = OP_RET;
      else if (jump_i)    op_o = OP_JUMP;
      else if (low_wr_i)  op_o = OP_LWR;
      else if (low_add_i) op_o = OP_LADD;
      else if (skip_i)    op_o = OP_SKIP;
      else if (step_i)    op_o = OP_STEP;
      else                op_o = OP_HOLD;
   end
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
   import pcs_pkg::*;
#(
   parameter int PC_W    = 11,
   parameter int LOW_W   = 8,
   parameter int INT_VEC = 8
) (
   input  pc_op_e            op_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [PC_W-1:0]   target_i,
   input  logic [LOW_W-1:0]  low_val_i,
   input  logic [PC_W-1:0]   pop_data_i,
   input  logic              pop_ok_i,
   output logic [PC_W-1:0]   pc_next_o,
   output logic [PC_W-1:0]   push_data_o
);
   localparam int HI_W = PC_W - LOW_W;

   logic [HI_W-1:0]  hi_part;
   logic [LOW_W-1:0] lo_part;
   logic [LOW_W-1:0] lo_sum;

   assign hi_part = pc_i[PC_W-1:LOW_W];
   assign lo_part = pc_i[LOW_W-1:0];
   assign lo_sum  = lo_part + low_val_i;   // carry out dropped (R6)

   always_comb begin
      unique case (op_i)
         OP_STEP: pc_next_o = pc_i + PC_W'(1);
         OP_SKIP: pc_next_o = pc_i + PC_W'(2);
         OP_JUMP,
         OP_CALL: pc_next_o = target_i;
         OP_RET:  pc_next_o = pop_ok_i ? pop_data_i : pc_i;
         OP_IRQ:  pc_next_o = PC_W'(INT_VEC);
         OP_LWR:  pc_next_o = {hi_part, low_val_i};
         OP_LADD: pc_next_o = {hi_part, lo_sum};
         default: pc_next_o = pc_i;
      endcase
   end

   assign push_data_o = (op_i == OP_IRQ) ? pc_i : pc_i + PC_W'(1);
endmodule

// File: rtl/pcs_lifo.sv
module pcs_lifo #(
   parameter int DEPTH = 8,
   parameter int AW    = 11
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        push_i,
   input  logic                        pop_i,
   input  logic [AW-1:0]               push_data_i,
   output logic [AW-1:0]               top_o,
   output logic                        empty_o,
   output logic [$clog2(DEPTH)-1:0]    sp_o,
   output logic                        ovf_o,
   output logic                        unf_o
);
   localparam int SP_W = $clog2(DEPTH);
   localparam int LW   = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << SP_W) != DEPTH) begin : g_bad_depth
         $error("pcs_lifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [LW-1:0]   lvl_q;
   logic [LW-1:0]   lvl_m1;
   logic [SP_W-1:0] sp_q;
   logic            full;
   logic            do_push;
   logic            do_pop;
   logic [AW-1:0]   slot_w [DEPTH];

   assign full    = (lvl_q == LW'(DEPTH));
   assign empty_o = (lvl_q == '0);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty_o;
   assign lvl_m1  = lvl_q - LW'(1);

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         logic [AW-1:0] q;
         always_ff @(posedge clk) begin
            if (do_push && lvl_q == LW'(gi)) q <= push_data_i;
         end
         assign slot_w[gi] = q;
      end
   endgenerate

   assign top_o = slot_w[lvl_m1[SP_W-1:0]];

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= '0;
         sp_q  <= '1;
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else begin
         if (push_i) begin
            if (full) ovf_o <= 1'b1;
            else begin
               lvl_q <= lvl_q + LW'(1);
               if (sp_q != '0) sp_q <= sp_q - SP_W'(1);
            end
         end else if (pop_i) begin
            if (empty_o) unf_o <= 1'b1;
            else begin
               lvl_q <= lvl_m1;
               if (!full) sp_q <= sp_q + SP_W'(1);
            end
         end
      end
   end

   assign sp_o = sp_q;

   assert_push_dec_R5: assert property (@(posedge clk) disable iff (rst)
      (push_i && sp_o != '0) |=> (sp_o == $past(sp_o) - SP_W'(1)));
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      (push_i && full) |=> (ovf_o && $stable(sp_o)));
   assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i && empty_o) |=> (unf_o && sp_o == '1));
endmodule

// File: rtl/pcs_top.sv
module pcs_top
   import pcs_pkg::*;
#(
   parameter int PC_W    = 11,
   parameter int LOW_W   = 8,
   parameter int DEPTH   = 8,
   parameter int INT_VEC = 8,
   parameter int RST_VEC = 0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      step_i,
   input  logic                      skip_i,
   input  logic                      jump_i,
   input  logic                      call_i,
   input  logic                      ret_i,
   input  logic                      irq_i,
   input  logic                      low_wr_i,
   input  logic                      low_add_i,
   input  logic [PC_W-1:0]           target_i,
   input  logic [LOW_W-1:0]          low_val_i,
   output logic [PC_W-1:0]           pc_o,
   output logic [$clog2(DEPTH)-1:0]  sp_o,
   output logic                      overflow_o,
   output logic                      underflow_o
);
   localparam int HI_W = PC_W - LOW_W;

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("pcs_top: PC_W must exceed LOW_W");
      end
      if (INT_VEC >= (1 << PC_W) || RST_VEC >= (1 << PC_W)) begin : g_bad_vec
         $error("pcs_top: vector outside PC range");
      end
   endgenerate

   pc_op_e          op;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_next;
   logic [PC_W-1:0] push_data;
   logic [PC_W-1:0] top_data;
   logic            stk_empty;
   logic            push;
   logic            pop;

   pcs_arbiter u_arb (
      .step_i(step_i), .skip_i(skip_i), .jump_i(jump_i), .call_i(call_i),
      .ret_i(ret_i), .irq_i(irq_i), .low_wr_i(low_wr_i), .low_add_i(low_add_i),
      .op_o(op)
   );

   assign push = (op == OP_CALL) || (op == OP_IRQ);
   assign pop  = (op == OP_RET);

   pcs_next_pc #(.PC_W(PC_W), .LOW_W(LOW_W), .INT_VEC(INT_VEC)) u_npc (
      .op_i(op), .pc_i(pc_q), .target_i(target_i), .low_val_i(low_val_i),
      .pop_data_i(top_data), .pop_ok_i(!stk_empty),
      .pc_next_o(pc_next), .push_data_o(push_data)
   );

   pcs_lifo #(.DEPTH(DEPTH), .AW(PC_W)) u_lifo (
      .clk(clk), .rst(rst), .push_i(push), .pop_i(pop),
      .push_data_i(push_data), .top_o(top_data), .empty_o(stk_empty),
      .sp_o(sp_o), .ovf_o(overflow_o), .unf_o(underflow_o)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= PC_W'(RST_VEC);
      else     pc_q <= pc_next;
   end

   assign pc_o = pc_q;

   assert_irq_vector_R4: assert property (@(posedge clk) disable iff (rst)
      irq_i |=> (pc_o == PC_W'(INT_VEC)));
   assert_call_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (call_i && ret_i && !irq_i) |=> (pc_o == $past(target_i)));
   assert_high_kept_R6: assert property (@(posedge clk) disable iff (rst)
      (op == OP_LADD) |=> (pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W])));
   assert_skip_two_R2: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SKIP) |=> (pc_o == $past(pc_o) + PC_W'(2)));
endmodule

// File: tb/sim_pcs_top.sv
module sim_pcs_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        step_i, skip_i, jump_i, call_i, ret_i, irq_i, low_wr_i, low_add_i;
   logic [10:0] target_i;
   logic [7:0]  low_val_i;
   logic [10:0] pc_o;
   logic [2:0]  sp_o;
   logic        overflow_o, underflow_o;

   int tests  = 0;
   int fails  = 0;

   logic [10:0] m_pc;
   logic [10:0] m_stk [8];
   int          m_lvl;
   logic        m_ovf, m_unf;

   always #5 clk = ~clk;

   pcs_top u0 (
      .clk(clk), .rst(rst), .step_i(step_i), .skip_i(skip_i), .jump_i(jump_i),
      .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i), .low_wr_i(low_wr_i),
      .low_add_i(low_add_i), .target_i(target_i), .low_val_i(low_val_i),
      .pc_o(pc_o), .sp_o(sp_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
   );

   function automatic logic [2:0] exp_sp();
      if (m_lvl == 0) return 3'd7;
      if (m_lvl >= 7) return 3'd0;
      return 3'(7 - m_lvl);
   endfunction

   task automatic m_push(input logic [10:0] a);
      if (m_lvl == 8) m_ovf = 1'b1;
      else begin
         m_stk[m_lvl] = a;
         m_lvl++;
      end
   endtask

   task automatic compare(input string req);
      tests++;
      if (pc_o !== m_pc || sp_o !== exp_sp() || overflow_o !== m_ovf || underflow_o !== m_unf) begin
         fails++;
         $display("FAIL %s: pc=%h sp=%b ovf=%b unf=%b expected pc=%h sp=%b ovf=%b unf=%b",
                  req, pc_o, sp_o, overflow_o, underflow_o, m_pc, exp_sp(), m_ovf, m_unf);
      end
   endtask

   // ops bits: 7 irq, 6 call, 5 ret, 4 jump, 3 low_wr, 2 low_add, 1 skip, 0 step
   task automatic cyc(input logic [7:0] ops, input logic [10:0] tgt,
                      input logic [7:0] v, input string req);
      {irq_i, call_i, ret_i, jump_i, low_wr_i, low_add_i, skip_i, step_i} = ops;
      target_i  = tgt;
      low_val_i = v;
      if (ops[7]) begin m_push(m_pc); m_pc = 11'h008; end
      else if (ops[6]) begin m_push(m_pc + 11'd1); m_pc = tgt; end
      else if (ops[5]) begin
         if (m_lvl == 0) m_unf = 1'b1;
         else begin m_lvl--; m_pc = m_stk[m_lvl]; end
      end
      else if (ops[4]) m_pc = tgt;
      else if (ops[3]) m_pc = {m_pc[10:8], v};
      else if (ops[2]) m_pc = {m_pc[10:8], 8'(m_pc[7:0] + v)};
      else if (ops[1]) m_pc = m_pc + 11'd2;
      else if (ops[0]) m_pc = m_pc + 11'd1;
      @(negedge clk);
      {irq_i, call_i, ret_i, jump_i, low_wr_i, low_add_i, skip_i, step_i} = '0;
      compare(req);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      {irq_i, call_i, ret_i, jump_i, low_wr_i, low_add_i, skip_i, step_i} = '0;
      target_i = '0; low_val_i = '0;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      m_pc = '0; m_lvl = 0; m_ovf = 1'b0; m_unf = 1'b0;
      compare("R1");
   endtask

   initial begin
      #2_000_000;
      fails++; tests++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R2 step, skip, wrap
      cyc(8'h01, 0, 0, "R2"); cyc(8'h01, 0, 0, "R2"); cyc(8'h02, 0, 0, "R2");
      cyc(8'h10, 11'h7FF, 0, "R3"); cyc(8'h01, 0, 0, "R2");
      cyc(8'h10, 11'h7FE, 0, "R3"); cyc(8'h02, 0, 0, "R2");
      cyc(8'h10, 11'h7FF, 0, "R3"); cyc(8'h02, 0, 0, "R2");
      // R6 low byte updates, carry dropped
      cyc(8'h10, 11'h3F0, 0, "R3"); cyc(8'h04, 0, 8'h20, "R6");
      for (int k = 0; k < 64; k++) cyc(8'h04, 0, 8'((k * 37 + 5) & 255), "R6");
      for (int k = 0; k < 16; k++) cyc(8'h08, 0, 8'(k * 17), "R6");
      // R3/R5 eight nested calls
      for (int k = 0; k < 8; k++) begin
         cyc(8'h01, 0, 0, "R2");
         cyc(8'h40, 11'(11'h100 + k * 11'h41), 0, "R5");
      end
      // R7 overflow on ninth push
      cyc(8'h40, 11'h555, 0, "R7");
      cyc(8'h80, 0, 0, "R7");
      // R8 unwind in reverse order, then underflow
      for (int k = 0; k < 8; k++) cyc(8'h20, 0, 0, "R8");
      cyc(8'h20, 0, 0, "R8");
      cyc(8'h20, 0, 0, "R8");
      // R4 interrupt beats everything and saves current PC
      do_reset();
      cyc(8'h10, 11'h2A7, 0, "R3");
      cyc(8'hFF, 11'h123, 8'h11, "R4");
      cyc(8'h20, 0, 0, "R4");
      // R9 call and return together
      cyc(8'h60, 11'h444, 0, "R9");
      cyc(8'h60, 11'h0AB, 0, "R9");
      cyc(8'h20, 0, 0, "R9");
      cyc(8'h20, 0, 0, "R9");
      // R9 sweep of all pulse combinations
      do_reset();
      for (int k = 0; k < 256; k++)
         cyc(8'(k), 11'((k * 83 + 7) & 11'h7FF), 8'((k * 29) & 255), "R9");
      for (int k = 0; k < 256; k++)
         cyc(8'(255 - k), 11'((k * 131) & 11'h7FF), 8'(k), "R9");
      do_reset();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule